// File: doc/BRIEF.md
# Hardware Cursor and Blink Generator

This block drives the cursor video bit of a character-cell display controller. Every character clock, it compares the live refresh address against a programmed 14-bit cursor address. It also checks the current scan line within the character row against a programmed band of lines. A cursor mode selects a steady cursor, no cursor, or one of two blink rates. The blink rates are derived from a frame counter that advances on a frame-start pulse.

The block registers the result once. It then passes the result through a skew delay of zero, one or two further character clocks, so that the cursor lines up with a delayed display-enable path elsewhere in the controller. One skew code turns the cursor off entirely. The block has no data stream: every pin is a plain control or status level sampled on each clock, with no valid/ready handshake and no back-pressure. One `clk` cycle is one character clock.

Top module: `cursor_gen`

## Requirements
- R1: While `rst_n` is low, `cursor_out` is 0 and the blink frame count is cleared to zero, so a blinking cursor starts in its visible phase.
- R2: A cursor hit requires `refresh_addr` to equal `cur_addr` in all 14 bits. The upper 6 bits carry the high address byte and the lower 8 bits carry the low byte.
- R3: A hit requires `cur_start <= row_addr <= cur_end`, with all three compared as unsigned 5-bit values.
- R4: When `cur_start > cur_end`, no scan line shows the cursor.
- R5: `cur_mode` = 2'b01 suppresses the cursor. `cur_mode` = 2'b00 shows it steadily in every frame, regardless of the frame count.
- R6: Each `frame_start` pulse sampled high advances a frame counter by one. With `cur_mode` = 2'b11 (fast), the cursor is visible while counter bit 3 is 0, so its phase flips every 8 frames.
- R7: With `cur_mode` = 2'b10 (slow), the cursor is visible while counter bit 4 is 0, so its phase flips every 16 frames.
- R8: The hit is registered once. `cur_skew` values 0, 1 and 2 make `cursor_out` equal to the hit computed from the inputs 1, 2 or 3 clocks earlier.
- R9: `cur_skew` = 2'b11 forces `cursor_out` to 0.
- R10: A hit requires `disp_en` high in the same cycle as the address and line compare.
- R11: The cursor appears in every frame that meets R2 to R10. No alternate-field or line-parity condition applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| disp_en | input | 1 | Undelayed display enable |
| refresh_addr | input | 14 | Current character refresh address |
| row_addr | input | 5 | Scan line within the character row |
| cur_addr | input | 14 | Cursor character address |
| cur_mode | input | 2 | 00 steady, 01 off, 10 slow blink, 11 fast blink |
| cur_start | input | 5 | First cursor scan line |
| cur_end | input | 5 | Last cursor scan line |
| cur_skew | input | 2 | Extra delay 0 to 2 clocks; 3 disables the cursor |
| cursor_out | output | 1 | Cursor video bit |

## Verification
Directed patterns come first, and each one isolates a single term of the hit:
- an address match with a line band around the current row, which separates the address compare from the line compare;
- a start line greater than the end line;
- the off mode;
- `disp_en` low while everything else matches;
- each skew code in turn, which tells the three delay taps and the disable code apart.

Long runs of fast and slow blink, with frames pulsed repeatedly, show which counter bit gates each rate. Seeded random traffic then mixes all the fields, with the address forced to match about half the time. A bench model predicts every cycle's output from its own frame count and delay history.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  typedef enum logic [1:0] {
    CM_STEADY = 2'b00,
    CM_OFF    = 2'b01,
    CM_SLOW   = 2'b10,
    CM_FAST   = 2'b11
  } curs_mode_e;

  localparam logic [1:0] SKEW_DISABLE = 2'b11;
endpackage

// File: rtl/cursor_blink.sv
module cursor_blink #(
  parameter int FAST_LOG2 = 3,
  parameter int SLOW_LOG2 = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_start,
  output logic [SLOW_LOG2:0]    frame_cnt,
  output logic                  fast_vis,
  output logic                  slow_vis
);
  localparam int CW = SLOW_LOG2 + 1;

  always_ff @(posedge clk) begin
    if (!rst_n)           frame_cnt <= '0;
    else if (frame_start) frame_cnt <= frame_cnt + CW'(1);
  end

  assign fast_vis = ~frame_cnt[FAST_LOG2];
  assign slow_vis = ~frame_cnt[SLOW_LOG2];
endmodule

// File: rtl/cursor_match.sv
module cursor_match
  import cursor_pkg::*;
#(
  parameter int AW = 14,
  parameter int RW = 5
) (
  input  logic [AW-1:0] refresh_addr,
  input  logic [AW-1:0] cur_addr,
  input  logic [RW-1:0] row_addr,
  input  logic [RW-1:0] cur_start,
  input  logic [RW-1:0] cur_end,
  input  logic          disp_en,
  input  curs_mode_e    mode,
  input  logic          fast_vis,
  input  logic          slow_vis,
  output logic          hit
);
  logic addr_eq, in_band, mode_vis;

  assign addr_eq = (refresh_addr == cur_addr);
  // an empty band (start above end) fails one of the two bounds
  assign in_band = (row_addr >= cur_start) && (row_addr <= cur_end);

  always_comb begin
    unique case (mode)
      CM_STEADY: mode_vis = 1'b1;
      CM_OFF:    mode_vis = 1'b0;
      CM_SLOW:   mode_vis = slow_vis;
      CM_FAST:   mode_vis = fast_vis;
      default:   mode_vis = 1'b0;
    endcase
  end

  assign hit = addr_eq && in_band && mode_vis && disp_en;
endmodule

// File: rtl/cursor_skew.sv
module cursor_skew
  import cursor_pkg::*;
#(
  parameter int MAX_SKEW = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit,
  input  logic [1:0] skew,
  output logic       cursor_out
);
  logic [MAX_SKEW:0] tap;

  always_ff @(posedge clk) begin
    if (!rst_n) tap[0] <= 1'b0;
    else        tap[0] <= hit;
  end

  genvar gi;
  generate
    for (gi = 1; gi <= MAX_SKEW; gi++) begin : g_tap
      always_ff @(posedge clk) begin
        if (!rst_n) tap[gi] <= 1'b0;
        else        tap[gi] <= tap[gi-1];
      end
    end
  endgenerate

  always_comb begin
    if (skew == SKEW_DISABLE || int'(skew) > MAX_SKEW) cursor_out = 1'b0;
    else                                               cursor_out = tap[skew];
  end
endmodule

// File: rtl/cursor_gen.sv
module cursor_gen
  import cursor_pkg::*;
#(
  parameter int AW        = 14,
  parameter int RW        = 5,
  parameter int FAST_LOG2 = 3,
  parameter int SLOW_LOG2 = 4,
  parameter int MAX_SKEW  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          disp_en,
  input  logic [AW-1:0] refresh_addr,
  input  logic [RW-1:0] row_addr,
  input  logic [AW-1:0] cur_addr,
  input  logic [1:0]    cur_mode,
  input  logic [RW-1:0] cur_start,
  input  logic [RW-1:0] cur_end,
  input  logic [1:0]    cur_skew,
  output logic          cursor_out
);
  logic [SLOW_LOG2:0] frame_cnt;
  logic fast_vis, slow_vis, hit;

  cursor_blink #(.FAST_LOG2(FAST_LOG2), .SLOW_LOG2(SLOW_LOG2)) u_blink (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .frame_cnt(frame_cnt), .fast_vis(fast_vis), .slow_vis(slow_vis)
  );

  cursor_match #(.AW(AW), .RW(RW)) u_match (
    .refresh_addr(refresh_addr), .cur_addr(cur_addr), .row_addr(row_addr),
    .cur_start(cur_start), .cur_end(cur_end), .disp_en(disp_en),
    .mode(curs_mode_e'(cur_mode)), .fast_vis(fast_vis), .slow_vis(slow_vis),
    .hit(hit)
  );

  cursor_skew #(.MAX_SKEW(MAX_SKEW)) u_skew (
    .clk(clk), .rst_n(rst_n), .hit(hit), .skew(cur_skew),
    .cursor_out(cursor_out)
  );
endmodule

// File: rtl/cursor_gen_chk.sv
module cursor_gen_chk #(
  parameter int AW = 14,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_start,
  input logic          disp_en,
  input logic [AW-1:0] refresh_addr,
  input logic [AW-1:0] cur_addr,
  input logic [1:0]    cur_mode,
  input logic [1:0]    cur_skew,
  input logic          cursor_out,
  input logic          hit_q,
  input logic [CW-1:0] frame_cnt
);
  // R10
  dispen_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> $past(disp_en));

  // R5
  mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> $past(cur_mode) != 2'b01);

  // R2
  addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> $past(refresh_addr) == $past(cur_addr));

  // R9
  skew_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_skew == 2'b11 |-> !cursor_out);

  // R8
  skew_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_skew == 2'b01 |-> cursor_out == $past(hit_q));

  // R6
  frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> frame_cnt == $past(frame_cnt) + CW'(1));

  // R6
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(frame_cnt));
endmodule

bind cursor_gen cursor_gen_chk #(.AW(AW), .CW(SLOW_LOG2 + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .disp_en(disp_en),
  .refresh_addr(refresh_addr), .cur_addr(cur_addr), .cur_mode(cur_mode),
  .cur_skew(cur_skew), .cursor_out(cursor_out), .hit_q(u_skew.tap[0]),
  .frame_cnt(frame_cnt)
);

// File: tb/tb_cursor_gen.sv
module tb_cursor_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic        disp_en = 1'b0;
  logic [13:0] refresh_addr = '0;
  logic [4:0]  row_addr = '0;
  logic [13:0] cur_addr = '0;
  logic [1:0]  cur_mode = '0;
  logic [4:0]  cur_start = '0;
  logic [4:0]  cur_end = '0;
  logic [1:0]  cur_skew = '0;
  logic        cursor_out;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [4:0] m_cnt = '0;
  logic [2:0] m_hist = '0;
  logic       done = 1'b0;

  always #5 clk = ~clk;

  cursor_gen dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .disp_en(disp_en),
    .refresh_addr(refresh_addr), .row_addr(row_addr), .cur_addr(cur_addr),
    .cur_mode(cur_mode), .cur_start(cur_start), .cur_end(cur_end),
    .cur_skew(cur_skew), .cursor_out(cursor_out)
  );

  function automatic logic model_hit();
    logic vis;
    case (cur_mode)
      2'b00: vis = 1'b1;
      2'b01: vis = 1'b0;
      2'b10: vis = ~m_cnt[4];
      default: vis = ~m_cnt[3];
    endcase
    return (refresh_addr == cur_addr) && disp_en && vis &&
           (row_addr >= cur_start) && (row_addr <= cur_end);
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: cursor_out=%0b expected=%0b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // one negedge: fold the inputs sampled at the last posedge into the model, then compare
  task automatic step(input string tag);
    logic exp;
    @(negedge clk);
    m_hist = {m_hist[1:0], model_hit()};
    if (frame_start) m_cnt = m_cnt + 5'd1;
    exp = (cur_skew == 2'b11) ? 1'b0 : m_hist[cur_skew];
    check(tag, cursor_out, exp);
  endtask

  task automatic settle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: output held low in reset
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      refresh_addr = 14'h0123; cur_addr = 14'h0123; disp_en = 1'b1;
      cur_start = 0; cur_end = 31; cur_mode = 2'b00;
      check("R1", cursor_out, 1'b0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    disp_en = 1'b0;
    settle("R1", 4);

    // R2 and R11: full address match, steady cursor, every frame
    cur_addr = 14'h2A5C; refresh_addr = 14'h2A5C; disp_en = 1'b1;
    cur_start = 5'd2; cur_end = 5'd6; row_addr = 5'd4;
    settle("R2", 4);
    refresh_addr = 14'h0A5C; settle("R2", 4);
    refresh_addr = 14'h2A5D; settle("R2", 4);
    refresh_addr = 14'h2A5C;
    for (int f = 0; f < 6; f++) begin
      frame_start = 1'b1; step("R11");
      frame_start = 1'b0; settle("R11", 3);
    end

    // R3: band edges
    for (int r = 0; r < 10; r++) begin
      row_addr = 5'(r);
      settle("R3", 1);
    end
    settle("R3", 3);

    // R4: empty band
    cur_start = 5'd7; cur_end = 5'd3;
    for (int r = 0; r < 10; r++) begin
      row_addr = 5'(r);
      settle("R4", 1);
    end
    cur_start = 5'd0; cur_end = 5'd31; row_addr = 5'd5;
    settle("R4", 3);

    // R5: off mode, then steady again
    cur_mode = 2'b01; settle("R5", 5);
    cur_mode = 2'b00; settle("R5", 5);

    // R10: display enable low
    disp_en = 1'b0; settle("R10", 4);
    disp_en = 1'b1; settle("R10", 4);

    // R8 and R9: each skew code with a single-cycle hit
    for (int s = 0; s < 4; s++) begin
      cur_skew = 2'(s);
      refresh_addr = 14'h0000; settle(s == 3 ? "R9" : "R8", 4);
      refresh_addr = 14'h2A5C; settle(s == 3 ? "R9" : "R8", 1);
      refresh_addr = 14'h0000; settle(s == 3 ? "R9" : "R8", 5);
    end
    cur_skew = 2'b00; refresh_addr = 14'h2A5C;

    // R6 and R7: blink rates across 40 frames each
    for (int md = 3; md >= 2; md--) begin
      cur_mode = 2'(md);
      for (int f = 0; f < 40; f++) begin
        frame_start = 1'b1; step(md == 3 ? "R6" : "R7");
        frame_start = 1'b0; settle(md == 3 ? "R6" : "R7", 2);
      end
    end

    // mixed random traffic
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      cur_addr     = 14'($urandom);
      refresh_addr = ($urandom % 2) ? cur_addr : 14'($urandom);
      row_addr     = 5'($urandom % 12);
      cur_start    = 5'($urandom % 10);
      cur_end      = 5'($urandom % 12);
      cur_mode     = 2'($urandom);
      disp_en      = ($urandom % 8) != 0;
      frame_start  = ($urandom % 6) == 0;
      if ($urandom % 16 == 0) cur_skew = 2'($urandom);
      step("R8");
    end
    frame_start = 1'b0;
    settle("R8", 4);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule